// File: doc/BRIEF.md
# DMA Destination Address and Acknowledge Channel Unit

This unit is the per-channel control datapath of a small DMA controller. It holds a five-bit channel control word that selects how the destination address moves after each transfer unit. For channels that support it, the word also selects which bus cycle drives the external acknowledge pin and at what polarity. A bus sequencer outside the unit marks each read and write cycle with a one-cycle strobe. The unit advances the destination address when a write cycle completes and drives the acknowledge pin while the chosen cycle is on the bus.

Software reaches the unit through a plain register write port. `cfg_sel` = 0 writes the control word from `cfg_wdata[4:0]`, and `cfg_sel` = 1 loads the destination address from `cfg_wdata`. The control word layout is:

- bit 0: acknowledge cycle select
- bit 1: acknowledge polarity
- bits 3:2: destination mode
- bit 4: sticky configuration-error flag when read, clear request when written

The control word can always be read on `cfg_rdata`. The channel index is a parameter. Channels with an index of 2 or more are built without the two acknowledge bits. There is no streaming data path: every pin is a plain control or status signal, so no valid/ready back-pressure rules apply.

Top module: `dma_dst_ack_unit`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `dst_addr` is 0 and `dack_pin` is low.
- R2: A write-cycle strobe with `xfer_active` high updates `dst_addr` at the next clock edge. Destination mode 00 holds the address, 01 adds the step and 10 subtracts it. Without such a strobe the address does not change.
- R3: `xfer_size` sets the step: 00 gives 1, 01 gives 2, 10 gives 4, and 11 gives 0, so the address does not move.
- R4: Address arithmetic wraps modulo 2^ADDR_W in both directions.
- R5: When `single_mode` and `dev_to_mem` are both high, the destination mode is ignored and the address holds.
- R6: In dual mode (`single_mode` low) with `xfer_active` high, acknowledge is asserted during `rd_cycle` when bit 0 is 0 and during `wr_cycle` when bit 0 is 1. It is not asserted in the other cycle.
- R7: In single mode with `xfer_active` high, acknowledge is asserted during either strobe, whatever the value of bit 0.
- R8: Bit 1 sets the polarity: 0 makes asserted high, 1 makes asserted low. When acknowledge is not asserted, including when `xfer_active` is low, the pin sits at the opposite level.
- R9: Writing destination mode 11 stores it so that it reads back, makes the unit hold the address, and sets bit 4. Bit 4 then stays set until a control write with bit 4 = 1 and a legal mode clears it.
- R10: With CH_INDEX >= ACK_CHANNELS (default 2), bits 0 and 1 always read 0 and writes to them have no effect. Such a channel acknowledges active-high during the read cycle in dual mode.
- R11: An address load (`cfg_sel` = 1) takes effect at the next edge and wins over a write-cycle update in the same cycle. A control write in the same cycle as an update leaves the old mode in force for that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0: control word, 1: destination address |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rdata | output | 5 | Control word readback, bit 4 is the error flag |
| xfer_active | input | 1 | A transfer is in progress on this channel |
| single_mode | input | 1 | 1: single-address, 0: dual-address |
| dev_to_mem | input | 1 | Direction is external device into address space |
| xfer_size | input | 2 | Transfer unit size code |
| rd_cycle | input | 1 | Read cycle strobe from the sequencer |
| wr_cycle | input | 1 | Write cycle strobe, marks unit completion |
| dst_addr | output | ADDR_W | Current destination address |
| dack_pin | output | 1 | External acknowledge pin |

## Verification
The hardest states to reach from the ports occur when two things land in the same edge or when a word edge is crossed. These include a load or a control write coinciding with a write strobe, an address crossing the all-ones boundary in either direction, and a channel without acknowledge bits receiving writes to them. The stimulus places these on purpose: it loads addresses next to the wrap point and issues writes together with strobes. It runs a full and a reduced channel side by side on identical inputs, both compared every clock against a behavioural model.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;

  typedef enum logic [1:0] {
    DST_HOLD = 2'b00,
    DST_UP   = 2'b01,
    DST_DOWN = 2'b10,
    DST_BAD  = 2'b11
  } dst_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  localparam int CTRL_W    = 5;
  localparam int BIT_AMODE = 0;
  localparam int BIT_LEVEL = 1;
  localparam int BIT_MODE  = 2;
  localparam int BIT_ERR   = 4;

  typedef struct packed {
    logic      err;
    dst_mode_e mode;
    logic      level;
    logic      amode;
  } ctrl_t;

  function automatic logic [2:0] step_of(input xfer_size_e sz);
    case (sz)
      SZ_BYTE: step_of = 3'd1;
      SZ_HALF: step_of = 3'd2;
      SZ_WORD: step_of = 3'd4;
      default: step_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_dst_pkg::*;
#(
  parameter bit HAS_ACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl
);

  logic      amode_q;
  logic      level_q;
  dst_mode_e mode_q;
  logic      err_q;
  dst_mode_e wmode;

  assign wmode = dst_mode_e'(wdata[BIT_MODE +: 2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= DST_HOLD;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= wmode;
      if (wmode == DST_BAD)
        err_q <= 1'b1;
      else if (wdata[BIT_ERR])
        err_q <= 1'b0;
    end
  end

  generate
    if (HAS_ACK) begin : g_ack_bits
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          amode_q <= 1'b0;
          level_q <= 1'b0;
        end else if (wr_en) begin
          amode_q <= wdata[BIT_AMODE];
          level_q <= wdata[BIT_LEVEL];
        end
      end
    end else begin : g_no_ack_bits
      assign amode_q = 1'b0;
      assign level_q = 1'b0;
    end
  endgenerate

  assign ctrl = '{err: err_q, mode: mode_q, level: level_q, amode: amode_q};

  // R9: storing the prohibited mode raises the error flag
  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[BIT_MODE +: 2] == 2'b11) |=> ctrl.err);

  // R9: the flag is sticky while nothing is written
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.err && !wr_en) |=> ctrl.err);

  // R9: the flag never rises without a control write
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.err && !wr_en) |=> !ctrl.err);

endmodule

// File: rtl/dma_dst_addr.sv
module dma_dst_addr
  import dma_dst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              unit_done,
  input  logic              hold_mode,
  input  dst_mode_e         mode,
  input  xfer_size_e        size,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] moved;

  assign step = ADDR_W'(step_of(size));

  always_comb begin
    case (mode)
      DST_UP:   moved = addr + step;
      DST_DOWN: moved = addr - step;
      default:  moved = addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= load_val;
    else if (unit_done && !hold_mode)
      addr <= moved;
  end

  // R11: a load wins and lands on the next edge
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_val));

  // R2: no unit completion, no movement
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_done && !load) |=> $stable(addr));

  // R5: device-to-memory single-address transfers leave the address alone
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && hold_mode && !load) |=> $stable(addr));

  // R3: word step while counting up
  a_r3_word_up: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !hold_mode && !load && mode == DST_UP && size == SZ_WORD)
      |=> addr == $past(addr) + ADDR_W'(4));

  // R2: fixed and prohibited modes hold
  a_r2_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !load && (mode == DST_HOLD || mode == DST_BAD)) |=> $stable(addr));

endmodule

// File: rtl/dma_ack_gen.sv
module dma_ack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_active,
  input  logic single_mode,
  input  logic rd_cycle,
  input  logic wr_cycle,
  input  logic amode,
  input  logic level,
  output logic ack_pin
);

  logic in_cycle;
  logic asserted;

  always_comb begin
    if (single_mode)
      in_cycle = rd_cycle | wr_cycle;
    else if (amode)
      in_cycle = wr_cycle;
    else
      in_cycle = rd_cycle;
  end

  assign asserted = xfer_active & in_cycle;
  assign ack_pin  = asserted ^ level;

  // R8: no transfer means the inactive level
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> ack_pin == level);

  // R7: single-address strobes always acknowledge
  a_r7_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && single_mode && (rd_cycle || wr_cycle)) |-> ack_pin != level);

  // R6: dual mode, write-cycle select ignores a lone read strobe
  a_r6_dual_wr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_mode && amode && rd_cycle && !wr_cycle) |-> ack_pin == level);

endmodule

// File: rtl/dma_dst_ack_unit.sv
module dma_dst_ack_unit
  import dma_dst_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CH_INDEX     = 0,
  parameter int ACK_CHANNELS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [4:0]        cfg_rdata,
  input  logic              xfer_active,
  input  logic              single_mode,
  input  logic              dev_to_mem,
  input  logic [1:0]        xfer_size,
  input  logic              rd_cycle,
  input  logic              wr_cycle,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dack_pin
);

  localparam bit HAS_ACK = (CH_INDEX < ACK_CHANNELS);

  ctrl_t ctrl;
  logic  ctrl_wr;
  logic  addr_wr;
  logic  unit_done;
  logic  hold_mode;

  assign ctrl_wr   = cfg_we & ~cfg_sel;
  assign addr_wr   = cfg_we &  cfg_sel;
  assign unit_done = xfer_active & wr_cycle;
  assign hold_mode = single_mode & dev_to_mem;

  dma_ctrl_reg #(.HAS_ACK(HAS_ACK)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctrl_wr),
    .wdata (cfg_wdata[CTRL_W-1:0]),
    .ctrl  (ctrl)
  );

  dma_dst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_wr),
    .load_val  (cfg_wdata),
    .unit_done (unit_done),
    .hold_mode (hold_mode),
    .mode      (ctrl.mode),
    .size      (xfer_size_e'(xfer_size)),
    .addr      (dst_addr)
  );

  dma_ack_gen u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .single_mode (single_mode),
    .rd_cycle    (rd_cycle),
    .wr_cycle    (wr_cycle),
    .amode       (ctrl.amode),
    .level       (ctrl.level),
    .ack_pin     (dack_pin)
  );

  assign cfg_rdata = ctrl;

  // R10: reduced channels keep the acknowledge bits at zero
  generate
    if (!HAS_ACK) begin : g_chk_noack
      a_r10_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> cfg_rdata[1:0] == 2'b00);
    end
  endgenerate

endmodule

// File: tb/sim_dma_dst_ack_unit.sv
`timescale 1ns/1ps
module sim_dma_dst_ack_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_active = 1'b0, single_mode = 1'b0, dev_to_mem = 1'b0;
  logic [1:0]  xfer_size = 2'b00;
  logic        rd_cycle = 1'b0, wr_cycle = 1'b0;
  logic [4:0]  rdata0, rdata1;
  logic [31:0] addr0, addr1;
  logic        pin0, pin1;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // model state, index 0 = full channel, 1 = reduced channel
  bit          m_am[2], m_al[2], m_err[2];
  int          m_mode[2];
  logic [31:0] m_addr[2];

  always #2 clk = ~clk;

  dma_dst_ack_unit #(.CH_INDEX(0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata0), .xfer_active(xfer_active), .single_mode(single_mode),
    .dev_to_mem(dev_to_mem), .xfer_size(xfer_size), .rd_cycle(rd_cycle),
    .wr_cycle(wr_cycle), .dst_addr(addr0), .dack_pin(pin0));

  dma_dst_ack_unit #(.CH_INDEX(2)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata1), .xfer_active(xfer_active), .single_mode(single_mode),
    .dev_to_mem(dev_to_mem), .xfer_size(xfer_size), .rd_cycle(rd_cycle),
    .wr_cycle(wr_cycle), .dst_addr(addr1), .dack_pin(pin1));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit exp_pin(input int i);
    bit act;
    if (!xfer_active) act = 0;
    else if (single_mode) act = rd_cycle | wr_cycle;
    else act = m_am[i] ? wr_cycle : rd_cycle;
    return act ^ m_al[i];
  endfunction

  function automatic logic [4:0] exp_rd(input int i);
    return {m_err[i], 2'(m_mode[i]), m_al[i], m_am[i]};
  endfunction

  task automatic compare();
    chk("u0 addr", addr0, m_addr[0]);
    chk("u0 rdata", 32'(rdata0), 32'(exp_rd(0)));
    chk("u0 ack", 32'(pin0), 32'(exp_pin(0)));
    chk("u1 addr", addr1, m_addr[1]);
    chk("u1 rdata", 32'(rdata1), 32'(exp_rd(1)));
    chk("u1 ack", 32'(pin1), 32'(exp_pin(1)));
  endtask

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_am[i] = 0; m_al[i] = 0; m_err[i] = 0; m_mode[i] = 0; m_addr[i] = '0;
      end else begin
        if (cfg_we && cfg_sel) m_addr[i] = cfg_wdata;
        else if (xfer_active && wr_cycle && !(single_mode && dev_to_mem)) begin
          int st;
          st = (xfer_size == 0) ? 1 : (xfer_size == 1) ? 2 : (xfer_size == 2) ? 4 : 0;
          if (m_mode[i] == 1) m_addr[i] = m_addr[i] + 32'(st);
          else if (m_mode[i] == 2) m_addr[i] = m_addr[i] - 32'(st);
        end
        if (cfg_we && !cfg_sel) begin
          m_am[i] = (i == 0) ? cfg_wdata[0] : 1'b0;
          m_al[i] = (i == 0) ? cfg_wdata[1] : 1'b0;
          m_mode[i] = int'(cfg_wdata[3:2]);
          if (m_mode[i] == 3) m_err[i] = 1;
          else if (cfg_wdata[4]) m_err[i] = 0;
        end
      end
    end
  endtask

  // one clock: compare mid-cycle, advance model at the edge, return at negedge
  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_we = 0; rd_cycle = 0; wr_cycle = 0;
  endtask

  task automatic wctrl(input logic [4:0] v);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'(v); cyc();
  endtask

  task automatic waddr(input logic [31:0] v);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = v; cyc();
  endtask

  task automatic unit(input logic [1:0] sz);
    xfer_active = 1; xfer_size = sz;
    rd_cycle = 1; cyc();
    xfer_size = sz; wr_cycle = 1; cyc();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_am[i] = 0; m_al[i] = 0; m_err[i] = 0; m_mode[i] = 0; m_addr[i] = '0;
    end
    @(negedge clk);
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1;
    repeat (2) cyc();

    cur_req = "R11"; waddr(32'h0000_0100);
    cur_req = "R2";
    unit(2'b00);                       // fixed mode
    wctrl(5'b00100);                   // count up
    unit(2'b00); unit(2'b00);
    xfer_active = 0; wr_cycle = 1; cyc(); // strobe without transfer
    wctrl(5'b01000);                   // count down
    unit(2'b00);
    cur_req = "R3";
    wctrl(5'b00100);
    for (int s = 0; s < 4; s++) unit(2'(s));
    wctrl(5'b01000);
    for (int s = 0; s < 4; s++) unit(2'(s));

    cur_req = "R4";
    wctrl(5'b00100); waddr(32'hFFFF_FFFE); unit(2'b10);
    wctrl(5'b01000); waddr(32'h0000_0001); unit(2'b01);

    cur_req = "R5";
    wctrl(5'b00100);
    single_mode = 1; dev_to_mem = 1; unit(2'b10); unit(2'b00);
    dev_to_mem = 0; unit(2'b10);
    single_mode = 0; dev_to_mem = 1; unit(2'b10);
    dev_to_mem = 0;

    cur_req = "R6";
    wctrl(5'b00101); unit(2'b00);
    wctrl(5'b00100); unit(2'b00);
    xfer_active = 1; rd_cycle = 1; wr_cycle = 1; cyc();

    cur_req = "R7";
    single_mode = 1;
    wctrl(5'b00101); unit(2'b00);
    wctrl(5'b00100); unit(2'b00);
    single_mode = 0;

    cur_req = "R8";
    wctrl(5'b00110); xfer_active = 0; cyc();
    unit(2'b00);
    wctrl(5'b00111); unit(2'b00);
    xfer_active = 0; cyc();

    cur_req = "R9";
    wctrl(5'b01100); unit(2'b10);
    wctrl(5'b00100); cyc();            // legal mode, no clear bit: flag stays
    wctrl(5'b11100); cyc();            // clear with prohibited mode: stays
    wctrl(5'b10100); cyc();            // clear
    unit(2'b10);

    cur_req = "R10";
    wctrl(5'b00111); unit(2'b00);
    wctrl(5'b00011); unit(2'b01);

    cur_req = "R11";
    wctrl(5'b00100);
    xfer_active = 1; wr_cycle = 1; xfer_size = 2'b10;
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'h1234_5678; cyc();
    xfer_active = 1; wr_cycle = 1; xfer_size = 2'b10;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h0000_0008; cyc();
    unit(2'b10);
    xfer_active = 0;
    repeat (2) cyc();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule